// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two 16-bit bidirectional ports, called A and B, and splits the bits into two groups of eight. Each group has two data paths, one from A to B and one from B to A. Each path has its own storage cell, and a latch enable for that path picks how the cell behaves. With the enable high the path is transparent. With the enable low the cell keeps its value, and it loads new data only when a shared capture clock rises. Port drive is enabled in layers: an active-low enable for each path, one active-low enable for the whole block, and a power-good input that overrides both.

Each pin is split into a data input, a data output and an output enable, and a testbench or pad ring resolves the real bus from these three. Each A pin also has a flag that shows whether some other device is driving it. When an A pin is not driven from outside and not driven by the block, a keeper presents the last level seen on that pin. The capture clock is treated as a data input and sampled on the system clock. A capture takes effect at the first system clock edge that sees the capture clock high after it was low.

Top module: `xcvr_bus_top`

## Requirements
- R1: In a group whose A-to-B latch enable is 1, the B data output of that group equals the present A pin level of that group in the same cycle.
- R2: In a path whose latch enable is 0, the output keeps its stored value over every system clock edge at which the sampled capture clock does not rise.
- R3: A capture clock rise is the capture clock sampled 1 at a system clock edge after it was sampled 0. At that edge, a path whose latch enable is 0 loads its source, and the new value shows on its output after the edge.
- R4: The B-to-A path behaves like the A-to-B path, using its own latch enable and output enable and the shared capture clock. Its source is the B data input of the same group.
- R5: With power good and the global enable 0, the enables of a group select its drive. AB=0,BA=0 drives both ports. AB=0,BA=1 drives B only. AB=1,BA=0 drives A only. AB=1,BA=1 drives neither.
- R6: When the global enable is 1, every bit of a_oe and b_oe is 0, whatever the path enables are.
- R7: Bits 7:0 form group 0 and bits 15:8 form group 1. The enables of one group (index 0 or 1) never change the data or the drive of the other group.
- R8: When pwr_ok is 0, every output enable bit is 0. Stored values are kept, so they show again once pwr_ok returns to 1.
- R9: The level of an A pin is a_out when a_oe is 1, otherwise a_in when a_ext is 1, and otherwise the level the keeper held at the previous system clock edge.
- R10: An active-low asynchronous reset clears every storage cell and keeper to 0. During reset the capture clock counts as sampled high, so reset alone never causes a capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_ok | input | 1 | Supply valid. When 0, no output is driven |
| oe_all_n | input | 1 | Global output enable, active low |
| oe_ab_n | input | 2 | A-to-B output enable for each group, active low |
| oe_ba_n | input | 2 | B-to-A output enable for each group, active low |
| le_ab | input | 2 | A-to-B latch enable for each group, high means transparent |
| le_ba | input | 2 | B-to-A latch enable for each group, high means transparent |
| cap_clk | input | 1 | Shared capture clock, sampled on clk |
| a_in | input | 16 | Level driven onto the A pins from outside |
| a_ext | input | 16 | High where an outside driver is active on an A pin |
| a_out | output | 16 | Data the block presents to the A pins |
| a_oe | output | 16 | A pin drive enable |
| b_in | input | 16 | Level on the B pins |
| b_out | output | 16 | Data the block presents to the B pins |
| b_oe | output | 16 | B pin drive enable |

## Verification
The data paths are tried with both groups transparent, both groups holding, and one group of each kind. The capture clock is held high while A data changes, and it is also made to rise, so a capture can be told apart from a hold and from a transparent pass. All four enable pairs are stepped through, both with the global enable and power good asserted and with them removed. This separates the per-path decode from the two overriding levels. Constrained random runs cover the rest. They mix partial outside drive on A with data the block drives back onto A, so the keeper has to hold levels that either side produced.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
    typedef enum logic [2:0] {
        DRV_OFF,
        DRV_ISOLATE,
        DRV_B_ONLY,
        DRV_A_ONLY,
        DRV_BOTH
    } drive_state_e;
endpackage

// File: rtl/xcvr_store_cell.sv
module xcvr_store_cell #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         le,
    input  logic         cap_rise,
    input  logic [W-1:0] src,
    output logic [W-1:0] dout
);
    logic [W-1:0] held_q;

    // Cell loads while open, or on a sampled capture-clock rise.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            held_q <= '0;
        else if (le || cap_rise)
            held_q <= src;
    end

    always_comb begin
        dout = le ? src : held_q;
    end
endmodule

// File: rtl/xcvr_drive_ctl.sv
module xcvr_drive_ctl
    import xcvr_pkg::*;
(
    input  logic pwr_ok,
    input  logic oe_all_n,
    input  logic oe_ab_n,
    input  logic oe_ba_n,
    output logic en_a,
    output logic en_b
);
    drive_state_e mode;

    // Mode selection: power state, then global enable, then path pair.
    always_comb begin
        if (!pwr_ok || oe_all_n)
            mode = DRV_OFF;
        else begin
            unique case ({oe_ab_n, oe_ba_n})
                2'b00:   mode = DRV_BOTH;
                2'b01:   mode = DRV_B_ONLY;
                2'b10:   mode = DRV_A_ONLY;
                default: mode = DRV_ISOLATE;
            endcase
        end
    end

    // Per-port drive from the mode.
    always_comb begin
        unique case (mode)
            DRV_BOTH:   begin en_a = 1'b1; en_b = 1'b1; end
            DRV_B_ONLY: begin en_a = 1'b0; en_b = 1'b1; end
            DRV_A_ONLY: begin en_a = 1'b1; en_b = 1'b0; end
            default:    begin en_a = 1'b0; en_b = 1'b0; end
        endcase
    end
endmodule

// File: rtl/xcvr_keeper.sv
module xcvr_keeper #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] own_oe,
    input  logic [W-1:0] own_val,
    input  logic [W-1:0] ext_en,
    input  logic [W-1:0] ext_val,
    output logic [W-1:0] lvl
);
    logic [W-1:0] keep_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            if (own_oe[i])
                lvl[i] = own_val[i];
            else if (ext_en[i])
                lvl[i] = ext_val[i];
            else
                lvl[i] = keep_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            keep_q <= '0;
        else
            keep_q <= lvl;
    end
endmodule

// File: rtl/xcvr_bus_top.sv
module xcvr_bus_top #(
    parameter int GRP_W = 8,
    parameter int N_GRP = 2,
    localparam int BUS_W = GRP_W * N_GRP
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_ok,
    input  logic             oe_all_n,
    input  logic [N_GRP-1:0] oe_ab_n,
    input  logic [N_GRP-1:0] oe_ba_n,
    input  logic [N_GRP-1:0] le_ab,
    input  logic [N_GRP-1:0] le_ba,
    input  logic             cap_clk,
    input  logic [BUS_W-1:0] a_in,
    input  logic [BUS_W-1:0] a_ext,
    output logic [BUS_W-1:0] a_out,
    output logic [BUS_W-1:0] a_oe,
    input  logic [BUS_W-1:0] b_in,
    output logic [BUS_W-1:0] b_out,
    output logic [BUS_W-1:0] b_oe
);
    logic cap_q;
    logic cap_rise;

    // Reset to 1 so a high capture clock at reset release is no rise (R10).
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cap_q <= 1'b1;
        else
            cap_q <= cap_clk;
    end

    always_comb begin
        cap_rise = cap_clk & ~cap_q;
    end

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        logic             en_a;
        logic             en_b;
        logic [GRP_W-1:0] a_lvl;
        logic [GRP_W-1:0] ab_dat;
        logic [GRP_W-1:0] ba_dat;

        xcvr_drive_ctl u_drv (
            .pwr_ok   (pwr_ok),
            .oe_all_n (oe_all_n),
            .oe_ab_n  (oe_ab_n[g]),
            .oe_ba_n  (oe_ba_n[g]),
            .en_a     (en_a),
            .en_b     (en_b)
        );

        xcvr_keeper #(.W(GRP_W)) u_keep (
            .clk     (clk),
            .rst_n   (rst_n),
            .own_oe  ({GRP_W{en_a}}),
            .own_val (ba_dat),
            .ext_en  (a_ext[g*GRP_W +: GRP_W]),
            .ext_val (a_in[g*GRP_W +: GRP_W]),
            .lvl     (a_lvl)
        );

        xcvr_store_cell #(.W(GRP_W)) u_ab (
            .clk      (clk),
            .rst_n    (rst_n),
            .le       (le_ab[g]),
            .cap_rise (cap_rise),
            .src      (a_lvl),
            .dout     (ab_dat)
        );

        xcvr_store_cell #(.W(GRP_W)) u_ba (
            .clk      (clk),
            .rst_n    (rst_n),
            .le       (le_ba[g]),
            .cap_rise (cap_rise),
            .src      (b_in[g*GRP_W +: GRP_W]),
            .dout     (ba_dat)
        );

        assign a_out[g*GRP_W +: GRP_W] = ba_dat;
        assign b_out[g*GRP_W +: GRP_W] = ab_dat;
        assign a_oe[g*GRP_W +: GRP_W]  = {GRP_W{en_a}};
        assign b_oe[g*GRP_W +: GRP_W]  = {GRP_W{en_b}};
    end
endmodule

// File: rtl/xcvr_bus_sva.sv
module xcvr_bus_sva #(
    parameter int GRP_W = 8,
    parameter int N_GRP = 2,
    localparam int BUS_W = GRP_W * N_GRP
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pwr_ok,
    input logic             oe_all_n,
    input logic [N_GRP-1:0] oe_ab_n,
    input logic [N_GRP-1:0] oe_ba_n,
    input logic [N_GRP-1:0] le_ab,
    input logic [N_GRP-1:0] le_ba,
    input logic             cap_clk,
    input logic [BUS_W-1:0] a_in,
    input logic [BUS_W-1:0] a_ext,
    input logic [BUS_W-1:0] a_out,
    input logic [BUS_W-1:0] a_oe,
    input logic [BUS_W-1:0] b_in,
    input logic [BUS_W-1:0] b_out,
    input logic [BUS_W-1:0] b_oe
);
    logic chk_cap_d;
    logic chk_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            chk_cap_d <= 1'b1;
        else
            chk_cap_d <= cap_clk;
    end
    assign chk_rise = cap_clk && !chk_cap_d;

    assert_pwr_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |-> (a_oe == '0 && b_oe == '0));

    assert_global_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        oe_all_n |-> (a_oe == '0 && b_oe == '0));

    for (genvar g = 0; g < N_GRP; g++) begin : g_chk
        assert_decode_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (pwr_ok && !oe_all_n) |->
                (b_oe[g*GRP_W] == !oe_ab_n[g] && a_oe[g*GRP_W] == !oe_ba_n[g]));

        assert_hold_ab_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (!le_ab[g] && !chk_rise) |=>
                (le_ab[g] || $stable(b_out[g*GRP_W +: GRP_W])));

        assert_hold_ba_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!le_ba[g] && !chk_rise) |=>
                (le_ba[g] || $stable(a_out[g*GRP_W +: GRP_W])));

        assert_capture_ab_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!le_ab[g] && chk_rise && (&a_ext[g*GRP_W +: GRP_W])
                && a_oe[g*GRP_W +: GRP_W] == '0) |=>
                (le_ab[g] || b_out[g*GRP_W +: GRP_W] == $past(a_in[g*GRP_W +: GRP_W])));

        assert_transp_ab_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (le_ab[g] && (&a_ext[g*GRP_W +: GRP_W]) && a_oe[g*GRP_W +: GRP_W] == '0) |->
                b_out[g*GRP_W +: GRP_W] == a_in[g*GRP_W +: GRP_W]);
    end
endmodule

bind xcvr_bus_top xcvr_bus_sva #(.GRP_W(GRP_W), .N_GRP(N_GRP)) u_sva (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .oe_all_n(oe_all_n),
    .oe_ab_n(oe_ab_n), .oe_ba_n(oe_ba_n), .le_ab(le_ab), .le_ba(le_ba),
    .cap_clk(cap_clk), .a_in(a_in), .a_ext(a_ext), .a_out(a_out),
    .a_oe(a_oe), .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
);

// File: tb/xcvr_bus_top_tb.sv
`timescale 1ns/1ps
module xcvr_bus_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_ok = 1'b1;
    logic        oe_all_n = 1'b0;
    logic [1:0]  oe_ab_n = 2'b00;
    logic [1:0]  oe_ba_n = 2'b00;
    logic [1:0]  le_ab = 2'b00;
    logic [1:0]  le_ba = 2'b00;
    logic        cap_clk = 1'b0;
    logic [15:0] a_in = '0;
    logic [15:0] a_ext = '1;
    logic [15:0] b_in = '0;
    logic [15:0] a_out, a_oe, b_out, b_oe;

    int checks = 0;
    int errors = 0;

    // Bench model state
    logic [7:0]  m_ab [2];
    logic [7:0]  m_ba [2];
    logic [15:0] m_keep;
    logic        m_capq;
    logic [15:0] e_a_out, e_a_oe, e_b_out, e_b_oe, e_alvl;

    always #2 clk = ~clk;

    xcvr_bus_top dut_i (
        .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .oe_all_n(oe_all_n),
        .oe_ab_n(oe_ab_n), .oe_ba_n(oe_ba_n), .le_ab(le_ab), .le_ba(le_ba),
        .cap_clk(cap_clk), .a_in(a_in), .a_ext(a_ext), .a_out(a_out),
        .a_oe(a_oe), .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
    );

    task automatic model_reset();
        m_ab[0] = '0; m_ab[1] = '0; m_ba[0] = '0; m_ba[1] = '0;
        m_keep = '0; m_capq = 1'b1;
    endtask

    task automatic calc();
        for (int g = 0; g < 2; g++) begin
            logic en;
            e_a_out[g*8 +: 8] = le_ba[g] ? b_in[g*8 +: 8] : m_ba[g];
            en = pwr_ok && !oe_all_n && !oe_ba_n[g];
            e_a_oe[g*8 +: 8] = {8{en}};
            en = pwr_ok && !oe_all_n && !oe_ab_n[g];
            e_b_oe[g*8 +: 8] = {8{en}};
        end
        for (int i = 0; i < 16; i++)
            e_alvl[i] = e_a_oe[i] ? e_a_out[i] : (a_ext[i] ? a_in[i] : m_keep[i]);
        for (int g = 0; g < 2; g++)
            e_b_out[g*8 +: 8] = le_ab[g] ? e_alvl[g*8 +: 8] : m_ab[g];
    endtask

    task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Check all outputs before the edge, then advance the model across it.
    task automatic cycle(string tag);
        logic rise;
        #1;
        calc();
        chk(tag, "a_out", a_out, e_a_out);
        chk(tag, "a_oe", a_oe, e_a_oe);
        chk(tag, "b_out", b_out, e_b_out);
        chk(tag, "b_oe", b_oe, e_b_oe);
        rise = cap_clk && !m_capq;
        @(posedge clk);
        if (rst_n) begin
            for (int g = 0; g < 2; g++) begin
                if (le_ab[g] || rise) m_ab[g] = e_alvl[g*8 +: 8];
                if (le_ba[g] || rise) m_ba[g] = b_in[g*8 +: 8];
            end
            m_keep = e_alvl;
            m_capq = cap_clk;
        end
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        checks++;
        errors++;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h1655_5eed));
        model_reset();
        @(negedge clk);
        // R10: reset state
        cycle("R10");
        cap_clk = 1'b1;
        cycle("R10");
        rst_n = 1'b1;
        cycle("R10");   // high capture clock at release: no capture
        cap_clk = 1'b0;
        cycle("R10");

        // R1: transparent A to B
        le_ab = 2'b11; a_in = 16'hA55A;
        cycle("R1");
        a_in = 16'h3CC3;
        cycle("R1");
        // R2: hold
        le_ab = 2'b00;
        cycle("R2");
        a_in = 16'hFFFF;
        cycle("R2");
        cycle("R2");
        // R3: capture on rise, not on a held-high level
        cap_clk = 1'b1;
        cycle("R3");
        a_in = 16'h1234;
        cycle("R3");
        cap_clk = 1'b0;
        cycle("R3");
        // R4: B to A
        le_ba = 2'b11; b_in = 16'hBEEF;
        cycle("R4");
        le_ba = 2'b00; b_in = 16'h0F0F;
        cycle("R4");
        cap_clk = 1'b1;
        cycle("R4");
        cap_clk = 1'b0;
        cycle("R4");
        // R5: all enable pairs
        for (int p = 0; p < 4; p++) begin
            oe_ab_n = {2{p[1]}}; oe_ba_n = {2{p[0]}};
            cycle("R5");
        end
        // R6: global enable
        oe_all_n = 1'b1; oe_ab_n = 2'b00; oe_ba_n = 2'b00;
        cycle("R6");
        oe_all_n = 1'b0;
        cycle("R6");
        // R7: groups independent
        oe_ba_n = 2'b11;
        le_ab = 2'b01; oe_ab_n = 2'b10; a_in = 16'h7E81;
        cycle("R7");
        a_in = 16'h9966;
        cycle("R7");
        le_ab = 2'b00; oe_ab_n = 2'b00;
        // R8: power off keeps storage
        pwr_ok = 1'b0;
        cycle("R8");
        b_in = 16'h5555;
        cycle("R8");
        pwr_ok = 1'b1;
        cycle("R8");
        // R9: bus hold on undriven A
        le_ab = 2'b11; a_in = 16'hC3A5;
        cycle("R9");
        a_ext = 16'h00FF; a_in = 16'h0000;
        cycle("R9");
        cycle("R9");
        oe_ba_n = 2'b00; le_ba = 2'b11; b_in = 16'h6B00;
        cycle("R9");
        oe_ba_n = 2'b11;
        cycle("R9");
        a_ext = '1; le_ba = 2'b00; le_ab = 2'b00;

        // Random mix
        for (int n = 0; n < 3000; n++) begin
            pwr_ok   = ($urandom % 16) != 0;
            oe_all_n = ($urandom % 8) == 0;
            oe_ab_n  = 2'($urandom);
            oe_ba_n  = 2'($urandom);
            le_ab    = 2'($urandom);
            le_ba    = 2'($urandom);
            cap_clk  = 1'($urandom);
            a_in     = 16'($urandom);
            a_ext    = 16'($urandom) | 16'($urandom);
            b_in     = 16'($urandom);
            if ($urandom % 2 == 0) cycle("R3"); else cycle("R9");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule